// File: doc/BRIEF.md
# Packet-to-Flit Segmenter with Multicast Replay

This block sits on the injection side of a tile's network interface. A tile unit such as a cache controller, a directory controller or a service unit hands it one whole packet. The packet arrives with its body, a message class, and a bitmask of destination tiles. The block stores the packet, cuts the body into fixed-size flit payloads, and sends those flits toward the router on the virtual channel that the message class selects. Each flit carries a header made of a kind code and the channel number.

A packet that names several destinations is not sent as one multicast flit stream. The stored copy is replayed, once for each destination, as a complete unicast packet. Destinations are served from the lowest index upward, and each one is removed from the stored mask once its copy has been sent. The block accepts no new packet until the mask is empty.

Flow control uses one on/off credit line per virtual channel. While the credit line for the packet's channel is off, nothing is sent and the current flit waits in place.

Top module: `flit_segmenter`

## Requirements
- R1: Each copy of a packet is sent as NFLIT = ceil(BODY_W / PAYLOAD_W) flits. Flit i carries bits [i*PAYLOAD_W +: PAYLOAD_W] of the body, so the lowest chunk is sent first. Bits past the top of the body are zero in the last flit.
- R2: `flit_kind` is 2'b00 on the first flit of a copy, 2'b10 on the last flit, and 2'b01 on every flit in between. When NFLIT is 1, the only flit of each copy carries 2'b11.
- R3: `flit_vcid` equals the `pkt_class` value captured when the packet was accepted, on every flit of every copy.
- R4: A packet is sent as one unicast copy for each set bit of `pkt_dest_mask`. Copies go out in ascending bit order, and `flit_dest` holds the index of the bit being served. No copy is sent for a clear bit.
- R5: `pkt_ready` is high while the block is idle. A packet is accepted on a clock edge where both `pkt_valid` and `pkt_ready` are high. `pkt_ready` stays low from the cycle after acceptance until the cycle after the last flit of the last copy. Packets offered while `pkt_ready` is low are ignored and do not change the flit stream.
- R6: While `vc_credit_on[class]` is low for the packet's channel, `flit_valid` is low and the position in the stream holds. The credit lines of other channels have no effect.
- R7: A packet whose destination mask is all zero is accepted and dropped. No flit is sent, and `pkt_ready` stays high.
- R8: After reset, `pkt_ready` is 1 and `flit_valid` is 0.
- R9: The first flit can be sent in the cycle after acceptance. After that, one flit is sent in every cycle where credit is on, with no idle cycle between one copy and the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | A packet is offered |
| pkt_ready | output | 1 | The block can accept a packet |
| pkt_body | input | BODY_W | Packet body |
| pkt_class | input | CLASS_W | Message class, which selects the virtual channel |
| pkt_dest_mask | input | NUM_DEST | One bit per destination tile |
| vc_credit_on | input | NUM_VC | Per-channel credit on/off from the router |
| flit_valid | output | 1 | A flit is sent in this cycle |
| flit_kind | output | 2 | Flit kind: head, body, tail or single |
| flit_vcid | output | CLASS_W | Virtual channel of the flit |
| flit_dest | output | DEST_W | Destination index of the current copy |
| flit_payload | output | PAYLOAD_W | Payload chunk |

## Verification
The flit outputs are decoded combinationally from registered state and from the live credit lines, so timing follows directly from the accepting edge. The first flit of a packet is due in the cycle that follows that edge. Each later flit is due in the first cycle after the previous flit in which the packet's credit line is on. `pkt_ready` is due high again in the cycle after the edge that sends the final tail.

The bench drives every input on the falling edge and samples the outputs 1 ns later, after credit has been applied for that cycle. It predicts, for each such cycle, whether a flit is due and what that flit should contain. The sweep covers every destination mask of a four-tile configuration, with a credit pattern that stalls the stream in irregular cycles. A second configuration, in which one flit holds the whole body, exercises the single-flit kind.

// File: rtl/seg_pkg.sv
package seg_pkg;

  typedef enum logic [1:0] {
    FK_HEAD   = 2'b00,
    FK_BODY   = 2'b01,
    FK_TAIL   = 2'b10,
    FK_SINGLE = 2'b11
  } flit_kind_e;

  // Kind from position within one copy; a one-flit copy is both first and last.
  function automatic flit_kind_e kind_of(input logic is_first, input logic is_last);
    if (is_first && is_last) return FK_SINGLE;
    if (is_first)            return FK_HEAD;
    if (is_last)             return FK_TAIL;
    return FK_BODY;
  endfunction

endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/seg_pkt_hold.sv
module seg_pkt_hold #(
  parameter int BODY_W  = 40,
  parameter int CLASS_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [BODY_W-1:0]  body_in,
  input  logic [CLASS_W-1:0] class_in,
  output logic [BODY_W-1:0]  body_q,
  output logic [CLASS_W-1:0] class_q
);
  logic [BODY_W-1:0]  body_d;
  logic [CLASS_W-1:0] class_d;

  always_comb begin
    body_d  = body_q;
    class_d = class_q;
    if (load_en) begin
      body_d  = body_in;
      class_d = class_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      body_q  <= '0;
      class_q <= '0;
    end else if (load_en) begin
      body_q  <= body_d;
      class_q <= class_d;
    end
  end
endmodule

// File: rtl/seg_dest_pick.sv
module seg_dest_pick #(
  parameter int NUM_DEST = 4,
  parameter int DEST_W   = 2
) (
  input  logic [NUM_DEST-1:0] mask,
  output logic [DEST_W-1:0]   pick_idx,
  output logic [NUM_DEST-1:0] pick_onehot
);
  // Lowest set bit wins: scan from the top so the last hit is the lowest.
  always_comb begin
    pick_idx = '0;
    for (int i = NUM_DEST - 1; i >= 0; i--) begin
      if (mask[i]) pick_idx = DEST_W'(i);
    end
  end

  always_comb begin
    pick_onehot = mask & (~mask + NUM_DEST'(1));
  end
endmodule

// File: rtl/seg_chunk_sel.sv
module seg_chunk_sel #(
  parameter int BODY_W    = 40,
  parameter int PAYLOAD_W = 16,
  parameter int NFLIT     = 3,
  parameter int IDX_W     = 2
) (
  input  logic [BODY_W-1:0]    body,
  input  logic [IDX_W-1:0]     idx,
  output logic [PAYLOAD_W-1:0] chunk
);
  localparam int PAD_W = NFLIT * PAYLOAD_W;

  logic [PAD_W-1:0]     padded;
  logic [PAYLOAD_W-1:0] slice [NFLIT];

  assign padded = PAD_W'(body);

  for (genvar g = 0; g < NFLIT; g++) begin : g_slice
    assign slice[g] = padded[g*PAYLOAD_W +: PAYLOAD_W];
  end

  always_comb begin
    chunk = '0;
    for (int i = 0; i < NFLIT; i++) begin
      if (idx == IDX_W'(i)) chunk = slice[i];
    end
  end
endmodule

// File: rtl/seg_ctrl.sv
module seg_ctrl #(
  parameter int NUM_DEST = 4,
  parameter int NFLIT    = 3,
  parameter int IDX_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pkt_valid,
  input  logic [NUM_DEST-1:0] pkt_dest_mask,
  input  logic                credit_sel,
  input  logic [NUM_DEST-1:0] pick_onehot,
  output logic                load_en,
  output logic                fire,
  output logic                busy_q,
  output logic [NUM_DEST-1:0] mask_q,
  output logic [IDX_W-1:0]    idx_q,
  output logic                first_flit,
  output logic                last_flit
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NFLIT - 1);

  logic                busy_d;
  logic [NUM_DEST-1:0] mask_d;
  logic [IDX_W-1:0]    idx_d;
  logic                state_en;

  always_comb begin
    load_en    = pkt_valid & ~busy_q;
    fire       = busy_q & credit_sel;
    first_flit = (idx_q == '0);
    last_flit  = (idx_q == LAST_IDX);
    state_en   = load_en | fire;
    busy_d     = busy_q;
    mask_d     = mask_q;
    idx_d      = idx_q;
    if (load_en) begin
      mask_d = pkt_dest_mask;
      busy_d = |pkt_dest_mask;
      idx_d  = '0;
    end else if (fire) begin
      if (last_flit) begin
        idx_d  = '0;
        mask_d = mask_q & ~pick_onehot;
        busy_d = |mask_d;
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mask_q <= '0;
      idx_q  <= '0;
    end else if (state_en) begin
      busy_q <= busy_d;
      mask_q <= mask_d;
      idx_q  <= idx_d;
    end
  end

  // R6: a cycle without credit leaves the stream position untouched
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !credit_sel) |=> ($stable(idx_q) && $stable(mask_q) && busy_q));

  // R4: retiring a copy removes exactly one destination
  assert_copy_retire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last_flit) |=> ($countones(mask_q) == $countones($past(mask_q)) - 1));

  // R9: within a copy the position advances by one per sent flit
  assert_step_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !last_flit) |=> (idx_q == $past(idx_q) + IDX_W'(1)));
endmodule

// File: rtl/flit_segmenter.sv
module flit_segmenter #(
  parameter int BODY_W    = 40,
  parameter int PAYLOAD_W = 16,
  parameter int NUM_DEST  = 4,
  parameter int NUM_VC    = 4,
  localparam int CLASS_W  = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int DEST_W   = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pkt_valid,
  output logic                 pkt_ready,
  input  logic [BODY_W-1:0]    pkt_body,
  input  logic [CLASS_W-1:0]   pkt_class,
  input  logic [NUM_DEST-1:0]  pkt_dest_mask,
  input  logic [NUM_VC-1:0]    vc_credit_on,
  output logic                 flit_valid,
  output logic [1:0]           flit_kind,
  output logic [CLASS_W-1:0]   flit_vcid,
  output logic [DEST_W-1:0]    flit_dest,
  output logic [PAYLOAD_W-1:0] flit_payload
);
  import seg_pkg::*;

  localparam int NFLIT = (BODY_W + PAYLOAD_W - 1) / PAYLOAD_W;
  localparam int IDX_W = (NFLIT > 1) ? $clog2(NFLIT) : 1;

  logic                rst_sync_n;
  logic                load_en;
  logic                fire;
  logic                busy_q;
  logic [NUM_DEST-1:0] mask_q;
  logic [IDX_W-1:0]    idx_q;
  logic                first_flit;
  logic                last_flit;
  logic [BODY_W-1:0]   body_q;
  logic [CLASS_W-1:0]  class_q;
  logic [NUM_DEST-1:0] pick_onehot;
  logic [DEST_W-1:0]   pick_idx;
  logic                credit_sel;

  seg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  seg_pkt_hold #(.BODY_W(BODY_W), .CLASS_W(CLASS_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_en  (load_en),
    .body_in  (pkt_body),
    .class_in (pkt_class),
    .body_q   (body_q),
    .class_q  (class_q)
  );

  seg_dest_pick #(.NUM_DEST(NUM_DEST), .DEST_W(DEST_W)) u_pick (
    .mask        (mask_q),
    .pick_idx    (pick_idx),
    .pick_onehot (pick_onehot)
  );

  assign credit_sel = vc_credit_on[class_q];

  seg_ctrl #(.NUM_DEST(NUM_DEST), .NFLIT(NFLIT), .IDX_W(IDX_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .pkt_valid     (pkt_valid),
    .pkt_dest_mask (pkt_dest_mask),
    .credit_sel    (credit_sel),
    .pick_onehot   (pick_onehot),
    .load_en       (load_en),
    .fire          (fire),
    .busy_q        (busy_q),
    .mask_q        (mask_q),
    .idx_q         (idx_q),
    .first_flit    (first_flit),
    .last_flit     (last_flit)
  );

  seg_chunk_sel #(.BODY_W(BODY_W), .PAYLOAD_W(PAYLOAD_W), .NFLIT(NFLIT), .IDX_W(IDX_W)) u_chunk (
    .body  (body_q),
    .idx   (idx_q),
    .chunk (flit_payload)
  );

  assign pkt_ready  = ~busy_q;
  assign flit_valid = fire;
  assign flit_kind  = kind_of(first_flit, last_flit);
  assign flit_vcid  = class_q;
  assign flit_dest  = pick_idx;

  // R6: a flit only leaves on a channel whose credit is on
  assert_credit_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid |-> vc_credit_on[flit_vcid]);

  // R5: no acceptance while a flit stream is in flight
  assert_ready_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_ready && flit_valid));

  // R4: the served destination is still pending in the stored mask
  assert_dest_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid |-> mask_q[flit_dest]);

  // R7: an empty mask never starts a stream
  assert_empty_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_ready && (pkt_dest_mask == '0)) |=> pkt_ready);
endmodule

// File: tb/sim_flit_segmenter.sv
module sim_flit_segmenter;
  localparam int BW = 40;
  localparam int PW = 16;
  localparam int ND = 4;
  localparam int NV = 4;
  localparam int NF = (BW + PW - 1) / PW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pkt_valid;
  logic          pkt_ready;
  logic [BW-1:0] pkt_body;
  logic [1:0]    pkt_class;
  logic [ND-1:0] pkt_dest_mask;
  logic [NV-1:0] vc_credit_on;
  logic          flit_valid;
  logic [1:0]    flit_kind;
  logic [1:0]    flit_vcid;
  logic [1:0]    flit_dest;
  logic [PW-1:0] flit_payload;

  logic          s_valid;
  logic          s_ready;
  logic [11:0]   s_body;
  logic [1:0]    s_class;
  logic [3:0]    s_mask;
  logic [3:0]    s_credit;
  logic          s_fvalid;
  logic [1:0]    s_kind;
  logic [1:0]    s_vcid;
  logic [1:0]    s_dest;
  logic [15:0]   s_payload;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flit_segmenter #(.BODY_W(BW), .PAYLOAD_W(PW), .NUM_DEST(ND), .NUM_VC(NV)) u0 (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_body(pkt_body), .pkt_class(pkt_class), .pkt_dest_mask(pkt_dest_mask),
    .vc_credit_on(vc_credit_on), .flit_valid(flit_valid), .flit_kind(flit_kind),
    .flit_vcid(flit_vcid), .flit_dest(flit_dest), .flit_payload(flit_payload)
  );

  flit_segmenter #(.BODY_W(12), .PAYLOAD_W(16), .NUM_DEST(4), .NUM_VC(4)) u1 (
    .clk(clk), .rst_n(rst_n), .pkt_valid(s_valid), .pkt_ready(s_ready),
    .pkt_body(s_body), .pkt_class(s_class), .pkt_dest_mask(s_mask),
    .vc_credit_on(s_credit), .flit_valid(s_fvalid), .flit_kind(s_kind),
    .flit_vcid(s_vcid), .flit_dest(s_dest), .flit_payload(s_payload)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int nth_dest(input logic [ND-1:0] m, input int c);
    int seen = 0;
    for (int i = 0; i < ND; i++) begin
      if (m[i]) begin
        if (seen == c) return i;
        seen++;
      end
    end
    return -1;
  endfunction

  task automatic run_pkt(input logic [BW-1:0] body, input logic [1:0] cls,
                         input logic [ND-1:0] mask);
    int total;
    int k;
    logic [NF*PW-1:0] padded;
    padded = {{(NF*PW-BW){1'b0}}, body};
    total = $countones(mask) * NF;
    @(negedge clk);
    pkt_valid = 1'b1; pkt_body = body; pkt_class = cls; pkt_dest_mask = mask;
    vc_credit_on = '0;
    #1 chk(pkt_ready == 1'b1, "R5", "ready idle", 64'(pkt_ready), 64'd1);
    @(negedge clk);
    k = 0;
    while (k < total) begin
      bit stall;
      int c;
      int i;
      logic [PW-1:0] exp_pl;
      logic [1:0] exp_kind;
      stall = ((cyc % 5) == 3) || ((cyc % 7) == 5);
      vc_credit_on = stall ? (~(NV'(1) << cls)) : (NV'(1) << cls);
      pkt_valid = 1'b1; pkt_body = ~body; pkt_class = cls + 2'd1; pkt_dest_mask = '1;
      #1;
      chk(pkt_ready == 1'b0, "R5", "ready busy", 64'(pkt_ready), 64'd0);
      if (stall) begin
        chk(flit_valid == 1'b0, "R6", "stalled valid", 64'(flit_valid), 64'd0);
      end else begin
        c = k / NF;
        i = k % NF;
        exp_pl = PW'(padded >> (i * PW));
        exp_kind = (NF == 1) ? 2'b11 : (i == 0) ? 2'b00 : (i == NF - 1) ? 2'b10 : 2'b01;
        chk(flit_valid == 1'b1, "R9", "flit due", 64'(flit_valid), 64'd1);
        chk(flit_kind == exp_kind, "R2", "kind", 64'(flit_kind), 64'(exp_kind));
        chk(flit_vcid == cls, "R3", "vcid", 64'(flit_vcid), 64'(cls));
        chk(int'(flit_dest) == nth_dest(mask, c), "R4", "dest",
            64'(flit_dest), 64'(nth_dest(mask, c)));
        chk(flit_payload == exp_pl, "R1", "payload", 64'(flit_payload), 64'(exp_pl));
        k++;
      end
      @(negedge clk);
    end
    pkt_valid = 1'b0;
    vc_credit_on = '1;
    #1;
    chk(pkt_ready == 1'b1, "R5", "ready after tail", 64'(pkt_ready), 64'd1);
    chk(flit_valid == 1'b0, (total == 0) ? "R7" : "R4", "no extra flit",
        64'(flit_valid), 64'd0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    pkt_valid = 1'b0; pkt_body = '0; pkt_class = '0; pkt_dest_mask = '0; vc_credit_on = '1;
    s_valid = 1'b0; s_body = '0; s_class = '0; s_mask = '0; s_credit = '1;
    repeat (3) @(negedge clk);
    #1;
    chk(pkt_ready == 1'b1, "R8", "reset ready", 64'(pkt_ready), 64'd1);
    chk(flit_valid == 1'b0, "R8", "reset valid", 64'(flit_valid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int m = 0; m < 16; m++) begin
      logic [BW-1:0] b;
      b = {8'(m * 37 + 1), 32'(m * 32'h9E3779B9)};
      run_pkt(b, 2'(m), 4'(m));
    end
    run_pkt('1, 2'd3, 4'b1001);
    run_pkt(40'h12_3456_789A, 2'd1, 4'b0110);

    // R2: single-flit configuration marks each copy as single kind
    @(negedge clk);
    s_valid = 1'b1; s_body = 12'hABC; s_class = 2'd2; s_mask = 4'b1010;
    @(negedge clk);
    s_valid = 1'b0;
    #1;
    chk(s_fvalid == 1'b1, "R9", "single first due", 64'(s_fvalid), 64'd1);
    chk(s_kind == 2'b11, "R2", "single kind", 64'(s_kind), 64'd3);
    chk(s_dest == 2'd1, "R4", "single dest a", 64'(s_dest), 64'd1);
    chk(s_payload == 16'h0ABC, "R1", "single pad", 64'(s_payload), 64'h0ABC);
    @(negedge clk);
    #1;
    chk(s_kind == 2'b11, "R2", "single kind b", 64'(s_kind), 64'd3);
    chk(s_dest == 2'd3, "R4", "single dest b", 64'(s_dest), 64'd3);
    chk(s_vcid == 2'd2, "R3", "single vcid", 64'(s_vcid), 64'd2);
    @(negedge clk);
    #1;
    chk(s_fvalid == 1'b0, "R4", "single done", 64'(s_fvalid), 64'd0);
    chk(s_ready == 1'b1, "R5", "single ready", 64'(s_ready), 64'd1);

    finish_run();
  end
endmodule